// File: doc/BRIEF.md
# Instruction Decoder and Jump Resolver

This block turns one 48-bit instruction word into the control and index values an execution pipeline needs, in a single combinational pass. The upper eight bits pick an opcode. Its high nibble names the format class: 0 for no-op, 1 for register arithmetic, 2 for immediate, 3 for jump and 4 for control. Its low nibble names the function inside that class. The block takes the register indices from the layout of that class, widens the immediate or target to 32 bits, and raises write enables for the destination register, the HI/LO pair and memory.

For jumps, the block reads the zero, sign and overflow flags and resolves the condition. It then gives the next instruction address. This is either the absolute target or the current address plus the six-byte instruction length. Control-class opcodes (stack, call, interrupt and flag operations) are only recognised and passed on as a function code, for a sequencer elsewhere to run. Unassigned opcodes, and register fields whose upper nibble is set, raise an invalid strobe and hold every effect low.

Top module: `kd_decoder`

## Requirements
- R1: Opcodes 0x10-0x1F (register class) give fmt=2 and rd_idx=instr[19:16], rs1_idx=instr[11:8], rs2_idx=instr[3:0]. They also give exec_op equal to the opcode low nibble, with 0..7 = add, sub, xor, or, and, shift-left, logical shift-right, arithmetic shift-right, 8..11 = mul, mulu, div, divu, and 12..15 = load byte, store byte, load word, store word. Bits [39:24] are ignored.
- R2: Opcodes 0x20-0x2F (immediate class, same low-nibble functions) give fmt=1, rd_idx=instr[35:32], rs1_idx=instr[27:24], use_imm=1 and imm_ext = instr[23:0] zero-extended to 32 bits.
- R3: Opcodes 0x40-0x49 (control functions 0..9: push register, pop register, push immediate, invalidate translation entry, return, call, software interrupt, interrupt return, set interrupt enable, clear interrupt enable) give fmt=0, ctrl_valid=1, ctrl_op = low nibble, rs1_idx=instr[27:24] and imm_ext = zero-extended instr[23:0]. No register, HI/LO or memory enable is raised.
- R4: Opcode 0x00 is a no-op: invalid=0, every enable, ctrl_valid and branch_taken low, and next_ip = cur_ip + 6.
- R5: rd_we is 1 only for functions 0..7, 12 and 14 of the register or immediate class, and only when the destination index is nonzero. A register-0 destination never raises rd_we.
- R6: Functions 8..11 raise hilo_we and never rd_we. In the immediate class, their destination field is not checked.
- R7: Functions 12 and 14 raise mem_rd, and 13 and 15 raise mem_wr. mem_byte is set for 12 and 13.
- R8: Jump opcodes 0x30-0x37 are taken as follows. 0x30 always. 0x31 when zero=1. 0x32 when sign=0. 0x33 when sign=1. 0x34 when zero=1 and sign=0. 0x35 when zero=1 and sign=1. 0x36 when overflow=1. 0x37 when overflow=0. They give fmt=3 and imm_ext = instr[31:0].
- R9: next_ip equals instr[31:0] when branch_taken=1, and cur_ip + 6 in every other case.
- R10: Every opcode other than 0x00, 0x10-0x2F, 0x30-0x37 and 0x40-0x49 raises invalid.
- R11: A nonzero upper nibble in a checked register field raises invalid. The checked fields are all three of the register class, rd and rs of the immediate class (rd excepted for functions 8..11), and rs1 of the control class. Jump bits [39:32] are ignored.
- R12: While invalid=1, rd_we, hilo_we, mem_rd, mem_wr, ctrl_valid and branch_taken are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 48 | Instruction word |
| flag_zero | input | 1 | Zero flag |
| flag_sign | input | 1 | Sign flag |
| flag_ovf | input | 1 | Overflow flag |
| cur_ip | input | 32 | Address of this instruction |
| fmt | output | 2 | Format class: 0 control, 1 immediate, 2 register, 3 jump |
| rd_idx | output | 4 | Destination register index |
| rs1_idx | output | 4 | First source register index |
| rs2_idx | output | 4 | Second source register index |
| imm_ext | output | 32 | Zero-extended immediate or jump target |
| exec_op | output | 4 | Execute function code |
| use_imm | output | 1 | Second operand is imm_ext |
| rd_we | output | 1 | Destination register write enable |
| hilo_we | output | 1 | HI/LO pair write enable |
| mem_rd | output | 1 | Memory load |
| mem_wr | output | 1 | Memory store |
| mem_byte | output | 1 | Memory access is one byte |
| ctrl_valid | output | 1 | Control-class operation present |
| ctrl_op | output | 4 | Control function code |
| branch_taken | output | 1 | Jump condition met |
| next_ip | output | 32 | Next instruction address |
| invalid | output | 1 | Invalid-opcode strobe |

## Verification
The checker assumes that instr, the flags and cur_ip are settled, known values whenever its combinational checks run, and that cur_ip + 6 wraps modulo 2^32. The bench changes inputs only on the falling clock edge and samples a nanosecond later. It drives every field with defined values, so no unknown bit ever reaches the decoder.

// File: rtl/kd_pkg.sv
package kd_pkg;

    localparam int FUNC_W = 4;
    localparam int CLS_W  = 4;
    localparam int OP_W   = CLS_W + FUNC_W;

    typedef enum logic [1:0] {
        FMT_CTRL = 2'd0,
        FMT_IMM  = 2'd1,
        FMT_REG  = 2'd2,
        FMT_JUMP = 2'd3
    } fmt_e;

    typedef enum logic [CLS_W-1:0] {
        CLS_NOP  = 4'h0,
        CLS_REG  = 4'h1,
        CLS_IMM  = 4'h2,
        CLS_JUMP = 4'h3,
        CLS_CTRL = 4'h4
    } cls_e;

    typedef enum logic [FUNC_W-1:0] {
        F_ADD, F_SUB, F_XOR, F_OR, F_AND, F_SHL, F_SHR, F_SAR,
        F_MUL, F_MULU, F_DIV, F_DIVU, F_LDB, F_STB, F_LDW, F_STW
    } func_e;

    typedef enum logic [FUNC_W-1:0] {
        JC_ALWAYS, JC_EQ, JC_LT, JC_GT, JC_LE, JC_GE, JC_LTU, JC_GTU
    } jcond_e;

    typedef enum logic [FUNC_W-1:0] {
        CT_PUSHR, CT_POPR, CT_PUSHI, CT_INVP, CT_RET,
        CT_CALL, CT_INT, CT_IRET, CT_SETIE, CT_CLRIE
    } ctrl_e;

    localparam logic [FUNC_W-1:0] JC_LAST = JC_GTU;
    localparam logic [FUNC_W-1:0] CT_LAST = CT_CLRIE;

    typedef struct packed {
        logic wants_rd;
        logic hilo;
        logic mem_rd;
        logic mem_wr;
        logic mem_byte;
    } exec_ctl_t;

    function automatic exec_ctl_t exec_ctl(input logic [FUNC_W-1:0] f);
        exec_ctl_t c;
        c = '0;
        unique case (f)
            F_ADD, F_SUB, F_XOR, F_OR, F_AND, F_SHL, F_SHR, F_SAR: c.wants_rd = 1'b1;
            F_MUL, F_MULU, F_DIV, F_DIVU:                          c.hilo     = 1'b1;
            F_LDB: begin c.wants_rd = 1'b1; c.mem_rd = 1'b1; c.mem_byte = 1'b1; end
            F_STB: begin c.mem_wr = 1'b1; c.mem_byte = 1'b1; end
            F_LDW: begin c.wants_rd = 1'b1; c.mem_rd = 1'b1; end
            F_STW: c.mem_wr = 1'b1;
            default: c = '0;
        endcase
        return c;
    endfunction

    function automatic logic is_muldiv(input logic [FUNC_W-1:0] f);
        return (f == F_MUL) || (f == F_MULU) || (f == F_DIV) || (f == F_DIVU);
    endfunction

endpackage

// File: rtl/kd_field_split.sv
module kd_field_split
    import kd_pkg::*;
#(
    parameter int INSTR_W = 48,
    parameter int FIELD_W = 8,
    parameter int IDX_W   = 4,
    parameter int IMM_W   = 24,
    parameter int ADDR_W  = 32
) (
    input  logic [INSTR_W-1:0]       instr,
    output logic [OP_W-1:0]          opcode,
    output logic [2:0][IDX_W-1:0]    r_idx,
    output logic [2:0]               r_hi,
    output logic [IDX_W-1:0]         i_rd_idx,
    output logic                     i_rd_hi,
    output logic [IDX_W-1:0]         i_rs_idx,
    output logic                     i_rs_hi,
    output logic [IMM_W-1:0]         imm,
    output logic [ADDR_W-1:0]        target
);

    localparam int HI_W   = FIELD_W - IDX_W;
    localparam int I_RD_LO = INSTR_W - OP_W - FIELD_W;
    localparam int I_RS_LO = INSTR_W - OP_W - 2 * FIELD_W;

    assign opcode = instr[INSTR_W-1 -: OP_W];

    // register-class fields: index 0 = rs2, 1 = rs1, 2 = rd
    for (genvar k = 0; k < 3; k++) begin : g_rfield
        localparam int LO = k * FIELD_W;
        assign r_idx[k] = instr[LO +: IDX_W];
        assign r_hi[k]  = |instr[LO + IDX_W +: HI_W];
    end

    assign i_rd_idx = instr[I_RD_LO +: IDX_W];
    assign i_rd_hi  = |instr[I_RD_LO + IDX_W +: HI_W];
    assign i_rs_idx = instr[I_RS_LO +: IDX_W];
    assign i_rs_hi  = |instr[I_RS_LO + IDX_W +: HI_W];
    assign imm      = instr[IMM_W-1:0];
    assign target   = instr[ADDR_W-1:0];

endmodule

// File: rtl/kd_op_class.sv
module kd_op_class
    import kd_pkg::*;
(
    input  logic [OP_W-1:0]   opcode,
    output cls_e              cls,
    output logic [FUNC_W-1:0] func,
    output logic              legal
);

    logic [CLS_W-1:0] cls_raw;

    assign cls_raw = opcode[OP_W-1 -: CLS_W];
    assign func    = opcode[FUNC_W-1:0];
    assign cls     = cls_e'(cls_raw);

    always_comb begin
        unique case (cls_raw)
            CLS_NOP:          legal = (func == '0);
            CLS_REG, CLS_IMM: legal = 1'b1;
            CLS_JUMP:         legal = (func <= JC_LAST);
            CLS_CTRL:         legal = (func <= CT_LAST);
            default:          legal = 1'b0;
        endcase
    end

endmodule

// File: rtl/kd_branch_eval.sv
module kd_branch_eval
    import kd_pkg::*;
(
    input  logic [FUNC_W-1:0] cond,
    input  logic              flag_zero,
    input  logic              flag_sign,
    input  logic              flag_ovf,
    output logic              cond_met
);

    always_comb begin
        unique case (cond)
            JC_ALWAYS: cond_met = 1'b1;
            JC_EQ:     cond_met = flag_zero;
            JC_LT:     cond_met = ~flag_sign;
            JC_GT:     cond_met = flag_sign;
            JC_LE:     cond_met = flag_zero & ~flag_sign;
            JC_GE:     cond_met = flag_zero & flag_sign;
            JC_LTU:    cond_met = flag_ovf;
            JC_GTU:    cond_met = ~flag_ovf;
            default:   cond_met = 1'b0;
        endcase
    end

endmodule

// File: rtl/kd_decoder.sv
module kd_decoder
    import kd_pkg::*;
#(
    parameter int INSTR_W = 48,
    parameter int FIELD_W = 8,
    parameter int IDX_W   = 4,
    parameter int IMM_W   = 24,
    parameter int ADDR_W  = 32,
    parameter int IP_STEP = INSTR_W / 8
) (
    input  logic [INSTR_W-1:0] instr,
    input  logic               flag_zero,
    input  logic               flag_sign,
    input  logic               flag_ovf,
    input  logic [ADDR_W-1:0]  cur_ip,
    output logic [1:0]         fmt,
    output logic [IDX_W-1:0]   rd_idx,
    output logic [IDX_W-1:0]   rs1_idx,
    output logic [IDX_W-1:0]   rs2_idx,
    output logic [ADDR_W-1:0]  imm_ext,
    output logic [FUNC_W-1:0]  exec_op,
    output logic               use_imm,
    output logic               rd_we,
    output logic               hilo_we,
    output logic               mem_rd,
    output logic               mem_wr,
    output logic               mem_byte,
    output logic               ctrl_valid,
    output logic [FUNC_W-1:0]  ctrl_op,
    output logic               branch_taken,
    output logic [ADDR_W-1:0]  next_ip,
    output logic               invalid
);

    localparam int EXT_W = ADDR_W - IMM_W;

    logic [OP_W-1:0]       opcode;
    logic [2:0][IDX_W-1:0] r_idx;
    logic [2:0]            r_hi;
    logic [IDX_W-1:0]      i_rd_idx, i_rs_idx;
    logic                  i_rd_hi, i_rs_hi;
    logic [IMM_W-1:0]      imm;
    logic [ADDR_W-1:0]     target;
    cls_e                  cls;
    logic [FUNC_W-1:0]     func;
    logic                  legal;
    logic                  cond_met;
    logic                  field_bad;
    exec_ctl_t             ctl;
    logic [ADDR_W-1:0]     seq_ip;

    kd_field_split #(
        .INSTR_W(INSTR_W), .FIELD_W(FIELD_W), .IDX_W(IDX_W),
        .IMM_W(IMM_W), .ADDR_W(ADDR_W)
    ) u_split (
        .instr(instr), .opcode(opcode), .r_idx(r_idx), .r_hi(r_hi),
        .i_rd_idx(i_rd_idx), .i_rd_hi(i_rd_hi),
        .i_rs_idx(i_rs_idx), .i_rs_hi(i_rs_hi),
        .imm(imm), .target(target)
    );

    kd_op_class u_class (
        .opcode(opcode), .cls(cls), .func(func), .legal(legal)
    );

    kd_branch_eval u_branch (
        .cond(func), .flag_zero(flag_zero), .flag_sign(flag_sign),
        .flag_ovf(flag_ovf), .cond_met(cond_met)
    );

    assign ctl    = exec_ctl(func);
    assign seq_ip = cur_ip + ADDR_W'(IP_STEP);

    // register fields whose upper bits must be clear, per class
    always_comb begin
        unique case (cls)
            CLS_REG:  field_bad = |r_hi;
            CLS_IMM:  field_bad = i_rs_hi | (i_rd_hi & ~is_muldiv(func));
            CLS_CTRL: field_bad = i_rs_hi;
            default:  field_bad = 1'b0;
        endcase
    end

    assign invalid = ~legal | field_bad;

    always_comb begin
        fmt          = FMT_CTRL;
        rd_idx       = '0;
        rs1_idx      = '0;
        rs2_idx      = '0;
        imm_ext      = '0;
        exec_op      = '0;
        use_imm      = 1'b0;
        rd_we        = 1'b0;
        hilo_we      = 1'b0;
        mem_rd       = 1'b0;
        mem_wr       = 1'b0;
        mem_byte     = 1'b0;
        ctrl_valid   = 1'b0;
        ctrl_op      = '0;
        branch_taken = 1'b0;
        if (!invalid) begin
            unique case (cls)
                CLS_REG: begin
                    fmt      = FMT_REG;
                    rd_idx   = r_idx[2];
                    rs1_idx  = r_idx[1];
                    rs2_idx  = r_idx[0];
                    exec_op  = func;
                    rd_we    = ctl.wants_rd & (r_idx[2] != '0);
                    hilo_we  = ctl.hilo;
                    mem_rd   = ctl.mem_rd;
                    mem_wr   = ctl.mem_wr;
                    mem_byte = ctl.mem_byte;
                end
                CLS_IMM: begin
                    fmt      = FMT_IMM;
                    rd_idx   = i_rd_idx;
                    rs1_idx  = i_rs_idx;
                    imm_ext  = {{EXT_W{1'b0}}, imm};
                    exec_op  = func;
                    use_imm  = 1'b1;
                    rd_we    = ctl.wants_rd & (i_rd_idx != '0);
                    hilo_we  = ctl.hilo;
                    mem_rd   = ctl.mem_rd;
                    mem_wr   = ctl.mem_wr;
                    mem_byte = ctl.mem_byte;
                end
                CLS_JUMP: begin
                    fmt          = FMT_JUMP;
                    imm_ext      = target;
                    branch_taken = cond_met;
                end
                CLS_CTRL: begin
                    fmt        = FMT_CTRL;
                    rs1_idx    = i_rs_idx;
                    imm_ext    = {{EXT_W{1'b0}}, imm};
                    ctrl_valid = 1'b1;
                    ctrl_op    = func;
                end
                default: ;
            endcase
        end
    end

    assign next_ip = branch_taken ? target : seq_ip;

endmodule

// File: rtl/kd_decoder_chk.sv
module kd_decoder_chk
    import kd_pkg::*;
#(
    parameter int INSTR_W = 48,
    parameter int IDX_W   = 4,
    parameter int ADDR_W  = 32,
    parameter int IP_STEP = 6
) (
    input logic [INSTR_W-1:0] instr,
    input logic [ADDR_W-1:0]  cur_ip,
    input logic [1:0]         fmt,
    input logic [IDX_W-1:0]   rd_idx,
    input logic               rd_we,
    input logic               hilo_we,
    input logic               mem_rd,
    input logic               mem_wr,
    input logic               ctrl_valid,
    input logic               branch_taken,
    input logic [ADDR_W-1:0]  next_ip,
    input logic               invalid
);

    logic any_effect;
    assign any_effect = rd_we | hilo_we | mem_rd | mem_wr | ctrl_valid | branch_taken;

    always_comb begin
        a_r5_no_write_r0: assert (!(rd_we && rd_idx == '0));
        a_r6_hilo_not_rd: assert (!(rd_we && hilo_we));
        a_r7_mem_dir_excl: assert (!(mem_rd && mem_wr));
        a_r12_invalid_quiet: assert (!(invalid && any_effect));
        a_r4_nop_quiet: assert (!(instr[INSTR_W-1 -: OP_W] == '0 && (invalid || any_effect)));
        a_r8_taken_only_jump: assert (!branch_taken || fmt == FMT_JUMP);
        a_r9_next_ip: assert (next_ip == (branch_taken ? instr[ADDR_W-1:0]
                                                        : cur_ip + ADDR_W'(IP_STEP)));
    end

endmodule

bind kd_decoder kd_decoder_chk #(
    .INSTR_W(INSTR_W), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .IP_STEP(IP_STEP)
) u_chk (
    .instr(instr), .cur_ip(cur_ip), .fmt(fmt), .rd_idx(rd_idx),
    .rd_we(rd_we), .hilo_we(hilo_we), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .ctrl_valid(ctrl_valid), .branch_taken(branch_taken),
    .next_ip(next_ip), .invalid(invalid)
);

// File: tb/tb_kd_decoder.sv
`timescale 1ns/1ps
module tb_kd_decoder;

    logic        clk = 1'b0;
    logic [47:0] instr = '0;
    logic        flag_zero = 1'b0, flag_sign = 1'b0, flag_ovf = 1'b0;
    logic [31:0] cur_ip = '0;
    logic [1:0]  fmt;
    logic [3:0]  rd_idx, rs1_idx, rs2_idx, exec_op, ctrl_op;
    logic [31:0] imm_ext, next_ip;
    logic        use_imm, rd_we, hilo_we, mem_rd, mem_wr, mem_byte;
    logic        ctrl_valid, branch_taken, invalid;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    kd_decoder dut (
        .instr(instr), .flag_zero(flag_zero), .flag_sign(flag_sign),
        .flag_ovf(flag_ovf), .cur_ip(cur_ip), .fmt(fmt), .rd_idx(rd_idx),
        .rs1_idx(rs1_idx), .rs2_idx(rs2_idx), .imm_ext(imm_ext),
        .exec_op(exec_op), .use_imm(use_imm), .rd_we(rd_we),
        .hilo_we(hilo_we), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_byte(mem_byte), .ctrl_valid(ctrl_valid), .ctrl_op(ctrl_op),
        .branch_taken(branch_taken), .next_ip(next_ip), .invalid(invalid)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic apply(input logic [47:0] w, input logic [2:0] zso, input logic [31:0] ip);
        @(negedge clk);
        instr     = w;
        flag_zero = zso[2];
        flag_sign = zso[1];
        flag_ovf  = zso[0];
        cur_ip    = ip;
        #1;
    endtask

    function automatic logic [4:0] exp_ctl(input int f);
        // {wants_rd, hilo, mem_rd, mem_wr, mem_byte}
        logic [4:0] c;
        c[4] = (f <= 7) || f == 12 || f == 14;
        c[3] = (f >= 8 && f <= 11);
        c[2] = (f == 12 || f == 14);
        c[1] = (f == 13 || f == 15);
        c[0] = (f == 12 || f == 13);
        return c;
    endfunction

    function automatic logic jump_exp(input int j, input logic z, input logic s, input logic o);
        case (j)
            0: return 1'b1;
            1: return z;
            2: return !s;
            3: return s;
            4: return z && !s;
            5: return z && s;
            6: return o;
            default: return !o;
        endcase
    endfunction

    task automatic t_nop;  // R4
        apply(48'h0, 3'b111, 32'h0000_1000);
        chk("R4", "invalid", invalid, 0);
        chk("R4", "effects", {rd_we, hilo_we, mem_rd, mem_wr, ctrl_valid, branch_taken}, 0);
        chk("R4", "next_ip", next_ip, 32'h0000_1006);
    endtask

    task automatic t_reg_class;  // R1 R5 R6 R7
        for (int f = 0; f < 16; f++) begin
            logic [4:0] c;
            c = exp_ctl(f);
            apply({4'h1, f[3:0], 16'hBEEF, 8'h03, 8'h05, 8'h09}, 3'b000, 32'h100);
            chk("R1", "fmt", fmt, 2);
            chk("R1", "idx", {rd_idx, rs1_idx, rs2_idx}, 12'h359);
            chk("R1", "exec_op", exec_op, f);
            chk("R1", "invalid", invalid, 0);
            chk("R5", "rd_we", rd_we, c[4]);
            chk("R6", "hilo_we", hilo_we, c[3]);
            chk("R7", "mem", {mem_rd, mem_wr, mem_byte}, c[2:0]);
        end
    endtask

    task automatic t_imm_class;  // R2 R6
        for (int f = 0; f < 16; f++) begin
            logic [4:0] c;
            c = exp_ctl(f);
            apply({4'h2, f[3:0], 8'h07, 8'h02, 24'hABCDEF}, 3'b000, 32'h200);
            chk("R2", "fmt", fmt, 1);
            chk("R2", "idx", {rd_idx, rs1_idx}, 8'h72);
            chk("R2", "imm_ext", imm_ext, 32'h00AB_CDEF);
            chk("R2", "use_imm", use_imm, 1);
            chk("R6", "rd/hilo", {rd_we, hilo_we}, {c[4], c[3]});
        end
        // R6: multiply-immediate ignores its destination byte
        apply({8'h28, 8'hFF, 8'h02, 24'h000010}, 3'b000, 32'h0);
        chk("R6", "muli invalid", invalid, 0);
        chk("R6", "muli rd/hilo", {rd_we, hilo_we}, 2'b01);
    endtask

    task automatic t_reg_zero;  // R5
        apply({8'h10, 16'h0, 8'h00, 8'h01, 8'h02}, 3'b000, 32'h0);
        chk("R5", "add r0 rd_we", rd_we, 0);
        apply({8'h2E, 8'h00, 8'h04, 24'h000008}, 3'b000, 32'h0);
        chk("R5", "ldw r0 rd_we", rd_we, 0);
        chk("R5", "ldw r0 mem_rd", mem_rd, 1);
    endtask

    task automatic t_jumps;  // R8 R9
        for (int j = 0; j < 8; j++) begin
            for (int fl = 0; fl < 8; fl++) begin
                logic e;
                e = jump_exp(j, fl[2], fl[1], fl[0]);
                apply({4'h3, j[3:0], 8'h00, 32'hCAFE_0000 + 32'(j)}, fl[2:0], 32'hFFFF_FFFC);
                chk("R8", "taken", branch_taken, e);
                chk("R9", "next_ip", next_ip, e ? 32'hCAFE_0000 + 32'(j) : 32'h0000_0002);
            end
        end
        apply({8'h30, 8'h00, 32'h1234_5678}, 3'b000, 32'h0);
        chk("R8", "fmt", fmt, 3);
        chk("R8", "target", imm_ext, 32'h1234_5678);
    endtask

    task automatic t_ctrl;  // R3
        for (int k = 0; k < 10; k++) begin
            apply({4'h4, k[3:0], 8'h00, 8'h0B, 24'h00_0123}, 3'b111, 32'h0);
            chk("R3", "ctrl", {ctrl_valid, ctrl_op, fmt}, {1'b1, k[3:0], 2'd0});
            chk("R3", "rs1/imm", {rs1_idx, imm_ext}, {4'hB, 32'h0000_0123});
            chk("R3", "no enables", {rd_we, hilo_we, mem_rd, mem_wr, branch_taken}, 0);
        end
    endtask

    task automatic t_opcode_sweep;  // R10 R12
        for (int op = 0; op < 256; op++) begin
            logic ok;
            ok = (op == 0) || (op >= 8'h10 && op <= 8'h2F) ||
                 (op >= 8'h30 && op <= 8'h37) || (op >= 8'h40 && op <= 8'h49);
            apply({op[7:0], 40'h0}, 3'b111, 32'h0);
            chk("R10", $sformatf("invalid op %02h", op), invalid, !ok);
            if (!ok)
                chk("R12", "quiet", {rd_we, hilo_we, mem_rd, mem_wr, ctrl_valid, branch_taken}, 0);
        end
    endtask

    task automatic t_field_nibble;  // R11 R1
        apply({8'h10, 16'h0, 8'h01, 8'h02, 8'h13}, 3'b000, 32'h0);
        chk("R11", "rs2 hi", invalid, 1);
        chk("R12", "rs2 hi quiet", rd_we, 0);
        apply({8'h20, 8'h80, 8'h01, 24'h1}, 3'b000, 32'h0);
        chk("R11", "imm rd hi", invalid, 1);
        apply({8'h40, 8'h00, 8'h21, 24'h1}, 3'b000, 32'h0);
        chk("R11", "ctrl rs1 hi", invalid, 1);
        chk("R12", "ctrl quiet", ctrl_valid, 0);
        apply({8'h30, 8'hFF, 32'h0000_4000}, 3'b000, 32'h0);
        chk("R11", "jump spare byte", {invalid, branch_taken}, 2'b01);
        apply({8'h11, 16'hFFFF, 8'h01, 8'h02, 8'h03}, 3'b000, 32'h0);
        chk("R1", "unused bits ignored", {invalid, rd_we}, 2'b01);
    endtask

    initial begin
        #(200_000 * 5);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_nop();
        t_reg_class();
        t_imm_class();
        t_reg_zero();
        t_jumps();
        t_ctrl();
        t_opcode_sweep();
        t_field_nibble();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule